// File: doc/BRIEF.md
# Store Handshake and Brownout Guard

This block decides when a copy of the SRAM array into nonvolatile cells may proceed. A copy attempt starts on an external request or when the supply comparator reports that the supply has dropped through its switch threshold. At the start of each attempt the block enables the pull-down on the shared open-drain handshake line and holds it for a fixed window, counted in clock cycles. The line level is sensed back through a synchronizer. If another device on the line holds it high for the whole window, the attempt is abandoned and an abort pulse is raised. If the line is seen low at any point, a go pulse lets the copy engine run.

A second comparator watches the backup-capacitor voltage. While that voltage is low, externally requested copies are refused and array writes are gated off. Automatic attempts caused by a falling supply are not refused. Each fall of the supply arms exactly one automatic attempt. A new attempt can only be armed after the supply has come back above the threshold.

Top module: `nv_store_guard`

## Requirements
- R1: After reset, the pull-down enable, go and abort outputs are all low.
- R2: An accepted external request turns on the pull-down enable in the next cycle. The enable then stays on for exactly WINDOW_CYC cycles.
- R3: A supply-low input that was low and is now high starts an automatic attempt with the same timing as R2. The capacitor-low input does not affect this.
- R4: A single fall of the supply produces only one attempt, however long supply-low stays high. A further attempt is armed only after supply-low has returned to 0.
- R5: If the synchronized handshake line reads 0 in any cycle of the window, go pulses high for one cycle in the cycle right after the window. Abort stays low.
- R6: If the line never reads 0 in the window, abort pulses high for one cycle in the cycle right after the window. Go never rises for that attempt.
- R7: While capacitor-low is 1, an external request is ignored and no attempt starts.
- R8: The write-enable output equals the write request while capacitor-low is 0, and is 0 while capacitor-low is 1.
- R9: An external request that arrives during a window is dropped. An automatic trigger that arrives during a window is held, and its attempt starts in the cycle after the window ends.
- R10: Because of the synchronizer, a line low that first appears later than 3 cycles before the window ends is not seen. A line that is released up to that point does count as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vcc_low_i | input | 1 | Supply below switch threshold |
| vcap_low_i | input | 1 | Backup capacitor below switch threshold |
| hsb_sense_i | input | 1 | Sensed level of the handshake line (asynchronous) |
| ext_store_req_i | input | 1 | External copy request, one-cycle pulse |
| wr_req_i | input | 1 | Array write request |
| hsb_pull_o | output | 1 | Pull-down enable for the handshake line |
| store_go_o | output | 1 | One-cycle pulse: the copy may run |
| store_abort_o | output | 1 | One-cycle pulse: the attempt was overridden |
| wr_en_o | output | 1 | Gated array write enable |

## Verification
Two collisions matter. The first is an automatic trigger and an external request landing in the same cycle. The bench raises both on the same edge and expects exactly one window and one go pulse, with no second window afterwards, because the automatic trigger was used by that single attempt. The second is an automatic trigger that arrives while a window is running. The bench raises supply-low part way through an external window and expects the go pulse of the first attempt and the pull-down of the held automatic attempt in adjacent cycles.

// File: rtl/nvsg_pkg.sv
package nvsg_pkg;
  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_PULL = 1'b1
  } sq_state_e;

  // True on the final cycle of a pull window of length win.
  function automatic logic at_window_end(input int unsigned cnt, input int unsigned win);
    return cnt == win - 1;
  endfunction

  // An attempt succeeds if the line was seen low earlier or is low now.
  function automatic logic line_claimed(input logic seen, input logic low_now);
    return seen | low_now;
  endfunction
endpackage

// File: rtl/nvsg_sync.sv
module nvsg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh_q <= '1;
        else        sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/nvsg_arm.sv
module nvsg_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_low_i,
  input  logic accept_i,
  output logic trig_o
);
  logic spent_q;

  assign trig_o = vcc_low_i & ~spent_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          spent_q <= 1'b0;
    else if (!vcc_low_i) spent_q <= 1'b0;
    else if (accept_i)   spent_q <= 1'b1;

  // R4
  one_shot_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> !trig_o);

  // R4
  rearm_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_low_i && $past(vcc_low_i) && !$past(trig_o)) |-> !trig_o);
endmodule

// File: rtl/nvsg_seq.sv
module nvsg_seq
  import nvsg_pkg::*;
#(
  parameter int WINDOW_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic hsb_low_i,
  output logic busy_o,
  output logic pull_o,
  output logic go_o,
  output logic abort_o
);
  localparam int CW = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;

  sq_state_e       state_q;
  logic [CW-1:0]   cnt_q;
  logic            seen_q;
  logic            last_cyc;
  logic            claimed;

  assign last_cyc = at_window_end(32'(cnt_q), WINDOW_CYC);
  assign claimed  = line_claimed(seen_q, hsb_low_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      go_o    <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      go_o    <= 1'b0;
      abort_o <= 1'b0;
      case (state_q)
        SQ_IDLE: if (start_i) begin
          state_q <= SQ_PULL;
          cnt_q   <= '0;
          seen_q  <= 1'b0;
        end
        SQ_PULL: begin
          if (hsb_low_i) seen_q <= 1'b1;
          if (last_cyc) begin
            state_q <= SQ_IDLE;
            go_o    <= claimed;
            abort_o <= ~claimed;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == SQ_PULL);
  assign pull_o = busy_o;

  // R2
  start_pulls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> pull_o);

  // R2
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_o |-> (32'(cnt_q) < WINDOW_CYC));

  // R5
  go_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_o |-> ($past(pull_o) && !pull_o));

  // R6
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_o && abort_o));

  // R6
  window_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pull_o) |-> (go_o || abort_o));
endmodule

// File: rtl/nv_store_guard.sv
module nv_store_guard #(
  parameter int WINDOW_CYC  = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_low_i,
  input  logic vcap_low_i,
  input  logic hsb_sense_i,
  input  logic ext_store_req_i,
  input  logic wr_req_i,
  output logic hsb_pull_o,
  output logic store_go_o,
  output logic store_abort_o,
  output logic wr_en_o
);
  logic hsb_s;
  logic auto_trig;
  logic ext_ok;
  logic busy;
  logic auto_accept;
  logic start;

  nvsg_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(hsb_sense_i), .q_o(hsb_s));

  assign ext_ok      = ext_store_req_i & ~vcap_low_i;
  assign auto_accept = auto_trig & ~busy;
  assign start       = ~busy & (auto_trig | ext_ok);

  nvsg_arm arm_i (
    .clk(clk), .rst_n(rst_n), .vcc_low_i(vcc_low_i),
    .accept_i(auto_accept), .trig_o(auto_trig));

  nvsg_seq #(.WINDOW_CYC(WINDOW_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .hsb_low_i(~hsb_s),
    .busy_o(busy), .pull_o(hsb_pull_o), .go_o(store_go_o),
    .abort_o(store_abort_o));

  assign wr_en_o = wr_req_i & ~vcap_low_i;

  // R7
  brownout_blocks_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ext_store_req_i && vcap_low_i && !auto_trig) |=> !hsb_pull_o);

  // R3
  auto_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_accept |=> hsb_pull_o);
endmodule

// File: tb/nv_store_guard_tb_top.sv
`timescale 1ns/1ps
module nv_store_guard_tb_top;
  localparam int W = 8;
  localparam int LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vcc_low = 1'b0, vcap_low = 1'b0, ext_req = 1'b0, wr_req = 1'b0;
  logic ext_hold = 1'b0;
  logic hsb_line;
  logic pull, go, abort_p, wr_en;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign hsb_line = ext_hold | ~pull;

  nv_store_guard #(.WINDOW_CYC(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .vcc_low_i(vcc_low), .vcap_low_i(vcap_low),
    .hsb_sense_i(hsb_line), .ext_store_req_i(ext_req), .wr_req_i(wr_req),
    .hsb_pull_o(pull), .store_go_o(go), .store_abort_o(abort_p), .wr_en_o(wr_en));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {auto, vcap, exp_start, exp_go, hold[3:0]}
  localparam logic [7:0] VEC [7] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 4'd0},   // R2 R5 line free
    {1'b0, 1'b0, 1'b1, 1'b1, 4'd5},   // R10 latest release still seen
    {1'b0, 1'b0, 1'b1, 1'b0, 4'd6},   // R10 one cycle too late
    {1'b0, 1'b0, 1'b1, 1'b0, 4'd10},  // R6 held past window
    {1'b0, 1'b1, 1'b0, 1'b0, 4'd0},   // R7 brownout refuses request
    {1'b1, 1'b1, 1'b1, 1'b1, 4'd0},   // R3 auto ignores brownout
    {1'b1, 1'b0, 1'b1, 1'b0, 4'd7}    // R3 R6 auto overridden
  };

  task automatic run_vec(input logic [7:0] v);
    int pulls = 0, gos = 0, aborts = 0;
    int hold = int'(v[3:0]);
    vcap_low = v[6];
    ext_hold = (hold > 0);
    if (v[7]) vcc_low = 1'b1; else ext_req = 1'b1;
    @(posedge clk); @(negedge clk);
    ext_req = 1'b0;
    check(v[6] && !v[7] ? "R7 start" : (v[7] ? "R3 start" : "R2 start"), int'(pull), int'(v[5]));
    for (int k = 0; k <= W + 1; k++) begin
      pulls += int'(pull); gos += int'(go); aborts += int'(abort_p);
      if (k == hold) ext_hold = 1'b0;
      @(negedge clk);
    end
    check("R2 window length", pulls, v[5] ? W : 0);
    check("R5 go count", gos, int'(v[4]));
    check("R6 abort count", aborts, int'(v[5] && !v[4]));
    ext_hold = 1'b0; vcc_low = 1'b0; vcap_low = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= LIMIT && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    check("R1 pull at reset", int'(pull), 0);
    check("R1 go at reset", int'(go), 0);
    check("R1 abort at reset", int'(abort_p), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pull after release", int'(pull), 0);

    for (int i = 0; i < 7; i++) run_vec(VEC[i]);

    // R8 write gate
    wr_req = 1'b1; #1;
    check("R8 write passes", int'(wr_en), 1);
    vcap_low = 1'b1; #1;
    check("R8 write blocked", int'(wr_en), 0);
    wr_req = 1'b0; #1;
    check("R8 idle write", int'(wr_en), 0);
    vcap_low = 1'b0;
    @(negedge clk);

    // R4 one attempt per fall, then re-arm
    vcc_low = 1'b1; cnt = 0;
    repeat (W + 20) begin @(negedge clk); cnt += int'(pull); end
    check("R4 single attempt", cnt, W);
    vcc_low = 1'b0; repeat (2) @(negedge clk);
    vcc_low = 1'b1; @(posedge clk); @(negedge clk);
    check("R4 rearmed", int'(pull), 1);
    repeat (W + 3) @(negedge clk);
    vcc_low = 1'b0; @(negedge clk);

    // R9 external request during window is dropped
    ext_req = 1'b1; @(posedge clk); @(negedge clk); ext_req = 1'b0;
    repeat (2) @(negedge clk);
    ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
    cnt = 0;
    repeat (W + 6) begin cnt += int'(pull); @(negedge clk); end
    check("R9 busy request dropped", cnt, W - 3);

    // R9 auto trigger held during window
    ext_req = 1'b1; @(posedge clk); @(negedge clk); ext_req = 1'b0;
    repeat (2) @(negedge clk);
    vcc_low = 1'b1;
    repeat (W - 2) @(negedge clk);
    check("R9 go of first attempt", int'(go), 1);
    check("R9 pull off at window end", int'(pull), 0);
    @(negedge clk);
    check("R9 held auto starts", int'(pull), 1);
    repeat (W + 3) @(negedge clk);
    vcc_low = 1'b0; @(negedge clk);

    // R3 R9 auto and external in the same cycle: one attempt only
    ext_req = 1'b1; vcc_low = 1'b1;
    @(posedge clk); @(negedge clk); ext_req = 1'b0;
    cnt = 0;
    repeat (W + 10) begin cnt += int'(pull); @(negedge clk); end
    check("R3 merged attempt", cnt, W);
    vcc_low = 1'b0; @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule